// File: doc/BRIEF.md
# PHY Register Access Bridge

A host CPU reaches an internal file of 16-bit PHY configuration registers through this bridge. The host sees a single 32-bit control word. One host store into that word starts one transaction. The store carries the direction, the register address and, for a write, the data. The bridge then asks the register file for the access over a request/acknowledge port and raises a busy flag in the same word. The host polls the word until busy drops. After a read, the fetched register value sits in the upper half of the word.

Only one transaction can be outstanding. A store that arrives while busy is set is dropped, so the transaction already in flight is never corrupted. The register file answers after a variable number of cycles. Addresses beyond the populated part of the file still complete, but a read from one of them yields zero whatever the back end returns.

Top module: `phy_reg_bridge`

## Requirements
- R1: While reset is held, and on the first cycle after it, the control word reads all zeros and `be_req` is low.
- R2: A host store with bit 0 set, accepted while idle, issues a back-end write from the next cycle: `be_we`=1, `be_addr` = stored bits 15:8, `be_wdata` = stored bits 31:16.
- R3: A host store with bit 0 clear, accepted while idle, issues a back-end read from the next cycle: `be_we`=0, `be_addr` = stored bits 15:8.
- R4: Bit 7 of the word (busy) reads 1 from the cycle after a store is accepted up to and including the cycle in which `be_ack` is seen. It reads 0 from the next cycle on. `be_req` is high exactly while busy is 1.
- R5: When a read to an address below `NUM_REGS` (default 48) completes, bits 31:16 of the word take the `be_rdata` value sampled with `be_ack`.
- R6: A read to an address at or above `NUM_REGS` completes normally, and bits 31:16 then read zero. A write to such an address is still issued and completes.
- R7: A host store made while busy is 1 is ignored: the back-end outputs and the final word are those of the transaction already in flight.
- R8: The word reflects the accepted command: bits 15:8 hold its address and bit 0 its direction. After a write completes, bits 31:16 still hold the written data.
- R9: Bits 6:1 always read 0, and the value a host stores into bit 7 has no effect.
- R10: While `be_req` is high and `be_ack` is low, `be_addr`, `be_we` and `be_wdata` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host store strobe into the control word |
| host_wdata | input | 32 | Value stored by the host: bit 0 direction (1 = write), 15:8 address, 31:16 write data |
| host_rdata | output | 32 | Control word as read by the host: bit 0 direction, bit 7 busy, 15:8 address, 31:16 data |
| be_req | output | 1 | Back-end request, held until acknowledged |
| be_we | output | 1 | Back-end direction, 1 = write |
| be_addr | output | 8 | Back-end register address |
| be_wdata | output | 16 | Back-end write data |
| be_ack | input | 1 | Back-end acknowledge, a one-cycle pulse while `be_req` is high |
| be_rdata | input | 16 | Back-end read data, valid with `be_ack` |

## Verification
The bench drives zero-latency acknowledges, in which busy lasts a single cycle. A bridge that cleared busy late or dropped the read data in that case would leave a stale word. It reads the first and last populated addresses, the first unpopulated address and the top address. The back-end model returns a non-zero filler value for unpopulated addresses, so a bridge that passed that value through would be caught. It stores a second command while busy, with another address, direction and data, and also at the edge where the acknowledge lands. A design that let that store through would show the wrong address in the back-end access or in the final word. It stores ones into the status and reserved bits, which a design that kept them would reflect back.

// File: rtl/prb_pkg.sv
// Shared layout of the host control word and the latched command record.
// Assumes a 32-bit word with an 8-bit address and 16-bit data field.
package prb_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int WORD_W   = 32;
    localparam int DIR_BIT  = 0;
    localparam int BUSY_BIT = 7;
    localparam int ADDR_LSB = 8;
    localparam int DATA_LSB = ADDR_LSB + ADDR_W;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } prb_cmd_t;
endpackage

// File: rtl/prb_cmd_unpack.sv
// Splits a host control word into direction, address and data.
// Pure wiring. Bits 7:1 of the stored value carry no command meaning.
module prb_cmd_unpack
    import prb_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output prb_cmd_t          cmd
);
    logic rsvd_unused;

    // extract the command fields from their fixed positions
    always_comb begin
        cmd.wr   = word[DIR_BIT];
        cmd.addr = word[ADDR_LSB +: ADDR_W];
        cmd.data = word[DATA_LSB +: DATA_W];
    end

    assign rsvd_unused = ^word[BUSY_BIT:DIR_BIT+1];
endmodule

// File: rtl/prb_xact_ctrl.sv
// Tracks the single outstanding transaction.
// A store is accepted only when idle. Busy ends on the acknowledge.
// Assumes be_ack is only meaningful while busy.
module prb_xact_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr,
    input  logic be_ack,
    output logic busy,
    output logic accept,
    output logic done
);
    logic busy_q;

    assign accept = host_wr & ~busy_q;
    assign done   = busy_q & be_ack;
    assign busy   = busy_q;

    // set busy after an accepted store, clear it on the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (accept) busy_q <= 1'b1;
        else if (done)   busy_q <= 1'b0;
    end
endmodule

// File: rtl/prb_word_reg.sv
// Holds the latched command and assembles the word the host reads back.
// A completed read replaces the data field, forced to zero when the
// address is outside the populated register file.
module prb_word_reg
    import prb_pkg::*;
#(
    parameter int unsigned NUM_REGS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              done,
    input  logic              busy,
    input  prb_cmd_t          cmd_in,
    input  logic [DATA_W-1:0] be_rdata,
    output prb_cmd_t          held,
    output logic [WORD_W-1:0] host_rdata
);
    localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(NUM_REGS);

    prb_cmd_t held_q;
    logic     in_range;

    assign in_range = (held_q.addr < ADDR_LIMIT);
    assign held     = held_q;

    // load a new command, or capture read data at completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (accept)
            held_q <= cmd_in;
        else if (done && !held_q.wr)
            held_q.data <= in_range ? be_rdata : '0;
    end

    // pack the host-visible word; reserved bits read zero
    always_comb begin
        host_rdata                       = '0;
        host_rdata[DIR_BIT]              = held_q.wr;
        host_rdata[BUSY_BIT]             = busy;
        host_rdata[ADDR_LSB +: ADDR_W]   = held_q.addr;
        host_rdata[DATA_LSB +: DATA_W]   = held_q.data;
    end
endmodule

// File: rtl/phy_reg_bridge.sv
// Top of the PHY register access bridge: host control word in front,
// request/acknowledge port toward the PHY register file behind.
// Assumes one outstanding transaction and an acknowledge pulse per request.
module phy_reg_bridge
    import prb_pkg::*;
#(
    parameter int unsigned NUM_REGS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              be_req,
    output logic              be_we,
    output logic [ADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0] be_wdata,
    input  logic              be_ack,
    input  logic [DATA_W-1:0] be_rdata
);
    prb_cmd_t cmd_in;
    prb_cmd_t held;
    logic     busy;
    logic     accept;
    logic     done;

    prb_cmd_unpack u_unpack (
        .word (host_wdata),
        .cmd  (cmd_in)
    );

    prb_xact_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_wr (host_wr),
        .be_ack  (be_ack),
        .busy    (busy),
        .accept  (accept),
        .done    (done)
    );

    prb_word_reg #(.NUM_REGS(NUM_REGS)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .done       (done),
        .busy       (busy),
        .cmd_in     (cmd_in),
        .be_rdata   (be_rdata),
        .held       (held),
        .host_rdata (host_rdata)
    );

    assign be_req   = busy;
    assign be_we    = held.wr;
    assign be_addr  = held.addr;
    assign be_wdata = held.data;
endmodule

// File: rtl/prb_checker.sv
// Temporal checks on the bridge ports, bound onto every instance of the top.
module prb_checker #(
    parameter int unsigned NUM_REGS = 48
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        w_dir,
    input logic [7:0]  w_addr,
    input logic [15:0] w_data,
    input logic [31:0] host_rdata,
    input logic        be_req,
    input logic        be_we,
    input logic [7:0]  be_addr,
    input logic [15:0] be_wdata,
    input logic        be_ack,
    input logic [15:0] be_rdata
);
    localparam logic [7:0] LIM = 8'(NUM_REGS);

    AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && !host_rdata[7] && w_dir |=> be_req && be_we
            && be_addr == $past(w_addr) && be_wdata == $past(w_data)); // R2
    AST_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && !host_rdata[7] && !w_dir |=> be_req && !be_we
            && be_addr == $past(w_addr)); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && !be_ack |=> be_req && host_rdata[7]); // R4
    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && be_ack |=> !be_req && !host_rdata[7]); // R4
    AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && be_ack && !be_we && be_addr < LIM
            |=> host_rdata[31:16] == $past(be_rdata)); // R5
    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && be_ack && !be_we && be_addr >= LIM
            |=> host_rdata[31:16] == 16'h0); // R6
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && host_wr && !be_ack |=> $stable(be_addr) && $stable(be_we)
            && $stable(be_wdata)); // R7
    AST_WORD_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> host_rdata[15:8] == be_addr && host_rdata[0] == be_we); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[6:1] == 6'h0); // R9
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && !be_ack |=> $stable(be_addr) && $stable(be_we)
            && $stable(be_wdata)); // R10
endmodule

bind phy_reg_bridge prb_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .w_dir      (host_wdata[0]),
    .w_addr     (host_wdata[15:8]),
    .w_data     (host_wdata[31:16]),
    .host_rdata (host_rdata),
    .be_req     (be_req),
    .be_we      (be_we),
    .be_addr    (be_addr),
    .be_wdata   (be_wdata),
    .be_ack     (be_ack),
    .be_rdata   (be_rdata)
);

// File: tb/phy_reg_bridge_tb.sv
module phy_reg_bridge_tb;
    localparam int NREG    = 48;
    localparam int MAX_LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        be_req, be_we;
    logic [7:0]  be_addr;
    logic [15:0] be_wdata;
    logic        be_ack = 1'b0;
    logic [15:0] be_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done_flag = 1'b0;
    int force_lat = -1;

    logic [15:0] phy_mem [NREG];
    logic [15:0] ref_mem [NREG];
    logic [7:0]  cap_addr;
    logic        cap_we;
    logic [15:0] cap_wdata;

    always #5 clk = ~clk;

    phy_reg_bridge #(.NUM_REGS(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .be_req(be_req), .be_we(be_we),
        .be_addr(be_addr), .be_wdata(be_wdata), .be_ack(be_ack),
        .be_rdata(be_rdata)
    );

    function automatic logic [15:0] init_val(int i);
        return 16'h3C5A ^ (16'(i) * 16'h0107);
    endfunction

    function automatic logic [31:0] exp_word(logic dir, logic [7:0] a, logic [15:0] d);
        logic [15:0] v;
        if (dir) v = d;
        else v = (a < 8'(NREG)) ? ref_mem[a] : 16'h0;
        return {v, a, 7'h0, dir};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // register-file model with variable acknowledge latency
    initial begin
        int lat;
        lat = -1;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                be_ack = 1'b0;
                lat = -1;
            end else if (be_ack) begin
                be_ack = 1'b0;
            end else if (be_req) begin
                if (lat < 0) lat = (force_lat >= 0) ? force_lat : int'($urandom_range(0, MAX_LAT));
                if (lat == 0) begin
                    cap_addr = be_addr;
                    cap_we = be_we;
                    cap_wdata = be_wdata;
                    if (be_addr < 8'(NREG)) begin
                        if (be_we) phy_mem[be_addr] = be_wdata;
                        be_rdata = phy_mem[be_addr];
                    end else begin
                        be_rdata = 16'hDEAD;
                    end
                    be_ack = 1'b1;
                    lat = -1;
                end else begin
                    lat--;
                end
            end
        end
    end

    // one host transaction, optionally with a store attempted while busy
    task automatic xact(logic dir, logic [7:0] a, logic [15:0] d, logic [6:0] junk,
                        bit intrude, string req);
        int polls;
        logic [31:0] e;
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = {d, a, junk, dir};
        @(negedge clk);
        host_wr = 1'b0;
        check("R4 busy set", {31'h0, host_rdata[7] & be_req}, 32'h1);
        check(dir ? "R2 issue" : "R3 issue", {15'h0, be_we, be_addr, (dir ? be_wdata : 16'h0)},
              {15'h0, dir, a, (dir ? d : 16'h0)});
        if (intrude) begin
            host_wr = 1'b1;
            host_wdata = {~d, ~a, 7'h7F, ~dir};
            @(negedge clk);
            host_wr = 1'b0;
        end
        polls = 0;
        while (host_rdata[7] && polls < 100) begin
            @(negedge clk);
            polls++;
        end
        check("R4 busy dropped", {31'h0, host_rdata[7] | be_req}, 32'h0);
        if (dir && a < 8'(NREG)) ref_mem[a] = d;
        e = exp_word(dir, a, d);
        check(dir ? "R8 word after write" : (a < 8'(NREG) ? "R5 read data" : "R6 high read"),
              host_rdata, e);
        check(intrude ? "R7 in-flight access kept" : "R10 access at ack",
              {7'h0, cap_we, cap_addr, (dir ? cap_wdata : 16'h0)},
              {7'h0, dir, a, (dir ? d : 16'h0)});
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done_flag) begin
                done_flag = 1'b1;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) begin
            phy_mem[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end
        repeat (3) @(negedge clk);
        check("R1 reset word", host_rdata, 32'h0);
        check("R1 reset req", {31'h0, be_req}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset word", host_rdata, 32'h0);

        force_lat = 0;
        xact(1'b0, 8'h00, 16'hFFFF, 7'h00, 1'b0, "R5");
        xact(1'b1, 8'h2F, 16'hBEEF, 7'h00, 1'b0, "R2");
        xact(1'b0, 8'h2F, 16'h0000, 7'h00, 1'b0, "R5");
        xact(1'b0, 8'h05, 16'h1234, 7'h00, 1'b1, "R7");
        force_lat = 3;
        xact(1'b0, 8'h30, 16'hAAAA, 7'h00, 1'b0, "R6");
        xact(1'b0, 8'hFF, 16'h5555, 7'h00, 1'b0, "R6");
        xact(1'b1, 8'h30, 16'h7777, 7'h00, 1'b0, "R6");
        xact(1'b0, 8'h30, 16'h0001, 7'h00, 1'b0, "R6");
        xact(1'b1, 8'h09, 16'h525C, 7'h7F, 1'b0, "R9");
        check("R9 reserved bits", {26'h0, host_rdata[6:1]}, 32'h0);
        xact(1'b0, 8'h09, 16'h0000, 7'h41, 1'b1, "R7");
        force_lat = -1;

        for (int k = 0; k < 300; k++) begin
            logic dir;
            logic [7:0] a;
            dir = 1'($urandom_range(0, 1));
            a = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(48, 255))
                                            : 8'($urandom_range(0, NREG - 1));
            xact(dir, a, 16'($urandom), 7'($urandom), bit'($urandom_range(0, 3) == 0), "RND");
        end

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule